// File: doc/BRIEF.md
# Framed Byte Command Register Bridge

This block sits behind a byte-wide serial transport, for example a two-wire or UART receiver, and turns short framed commands into accesses on an internal register bus. Bytes come in one at a time on a valid/ready stream. A frame opens with the marker 0x55, carries a one-byte command code and closes with the marker 0xAA. A read or write frame also carries a big-endian word address and, for a write, a big-endian data word. Each accepted frame produces exactly one action: a single register read, a single register write, or a one-cycle reset pulse to the attached cores.

After the action, or after rejecting the frame, the block returns a framed response on an output byte stream. Responses use the two markers the other way round: they open with 0xAA and close with 0x55. The response length follows from its status code. Successful reads and writes echo the address. Rejected frames carry an error status and the offending command code.

While a command is executing or its response is draining, the input stream stalls. A host can therefore keep exactly one command outstanding.

Top module: `frame_cmd_engine`

## Requirements
- R1: While waiting for a frame, any input byte other than 0x55 is accepted and dropped, with no response, no bus access and no reset pulse.
- R2: The write frame is 0x55, 0x11, address bytes high first, data bytes most significant first, 0xAA. It causes exactly one bus cycle with bus_cs and bus_we high, carrying that address and data (the first data byte lands in bits 31:24). The response is 0xAA, 0x7E, address high, address low, 0x55.
- R3: The read frame is 0x55, 0x10, address high, address low, 0xAA. It causes exactly one bus cycle with bus_cs high and bus_we low. bus_rdata is sampled on the clock edge that ends the cycle following that bus cycle. The response is 0xAA, 0x7F, address high, address low, the four data bytes most significant first, 0x55.
- R4: The frame 0x55, 0x01, 0xAA raises core_rst for exactly one cycle, with no bus access. The response is 0xAA, 0x7D, 0x55.
- R5: A command code other than 0x10, 0x11 or 0x01 ends the frame at once. It produces no bus access and no reset. The response is 0xAA, 0xFE, the received code, 0x55.
- R6: When the byte in the end-marker position is not 0xAA, there is no bus access and no reset. The response is 0xAA, 0xFD, the command code, 0x55.
- R7: in_ready is low while a response byte is being offered and while a command is executing, so no input byte is taken during that time.
- R8: Once out_valid is high, it stays high with out_data unchanged until out_ready accepts the byte.
- R9: bus_cs never stays high for two consecutive cycles.
- R10: After reset, out_valid, bus_cs and core_rst are low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block takes the input byte this cycle |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Response byte present |
| out_ready | input | 1 | Receiver takes the response byte |
| out_data | output | 8 | Response byte |
| bus_cs | output | 1 | Register bus select, one cycle per access |
| bus_we | output | 1 | Write enable, qualified by bus_cs |
| bus_addr | output | ADDR_W | Register word address |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data, valid the cycle after a read select |
| core_rst | output | 1 | One-cycle reset pulse to attached cores |

## Verification
The bench builds the block with its defaults: a 16-bit address and a 32-bit data word. With these values the longest response, a 9-byte read reply, fills the whole response buffer, and a nonzero address high byte shows whether the address bytes are placed in the right order. A small register model that answers one cycle late lets the bench observe lost writes, a wrong data byte order and reads taken from the wrong cycle. Extra bus cycles or reset pulses on rejected frames appear in cycle counts that the bench keeps for each frame.

// File: rtl/fce_pkg.sv
package fce_pkg;

    localparam logic [7:0] CMD_SOF = 8'h55;
    localparam logic [7:0] CMD_EOF = 8'hAA;
    localparam logic [7:0] RSP_SOF = 8'hAA;
    localparam logic [7:0] RSP_EOF = 8'h55;

    localparam logic [7:0] OP_RD  = 8'h10;
    localparam logic [7:0] OP_WR  = 8'h11;
    localparam logic [7:0] OP_RST = 8'h01;

    localparam logic [7:0] ST_RD  = 8'h7F;
    localparam logic [7:0] ST_WR  = 8'h7E;
    localparam logic [7:0] ST_RST = 8'h7D;
    localparam logic [7:0] ST_UNK = 8'hFE;
    localparam logic [7:0] ST_BAD = 8'hFD;

    typedef enum logic [3:0] {
        PS_IDLE,
        PS_CODE,
        PS_ADDR,
        PS_DATA,
        PS_END,
        PS_EXEC,
        PS_CAPT,
        PS_SEND,
        PS_DRAIN
    } pstate_t;

    typedef enum logic [2:0] {
        RK_READ,
        RK_WRITE,
        RK_RESET,
        RK_UNK,
        RK_BAD
    } rkind_t;

endpackage

// File: rtl/fce_cmd_parser.sv
module fce_cmd_parser
    import fce_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int RSP_MAX = 9,
    parameter int LEN_W   = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  logic [7:0]                    in_data,
    output logic                          bus_cs,
    output logic                          bus_we,
    output logic [ADDR_W-1:0]             bus_addr,
    output logic [DATA_W-1:0]             bus_wdata,
    input  logic [DATA_W-1:0]             bus_rdata,
    output logic                          core_rst,
    output logic                          rsp_load,
    output logic [RSP_MAX-1:0][7:0]       rsp_bytes,
    output logic [LEN_W-1:0]              rsp_len,
    input  logic                          tx_busy
);

    localparam int AB    = ADDR_W / 8;
    localparam int DB    = DATA_W / 8;
    localparam int CNT_W = $clog2(AB + DB + 1);

    typedef struct packed {
        pstate_t           st;
        rkind_t            rk;
        logic [7:0]        code;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic [CNT_W-1:0]  cnt;
    } pctx_t;

    pctx_t cur_q, nxt_d;
    logic  fire;

    always_comb begin
        nxt_d    = cur_q;
        in_ready = (cur_q.st == PS_IDLE) || (cur_q.st == PS_CODE) ||
                   (cur_q.st == PS_ADDR) || (cur_q.st == PS_DATA) ||
                   (cur_q.st == PS_END);
        fire     = in_valid && in_ready;
        bus_cs   = 1'b0;
        bus_we   = 1'b0;
        core_rst = 1'b0;
        rsp_load = 1'b0;

        case (cur_q.st)
            PS_IDLE: begin
                if (fire && (in_data == CMD_SOF)) nxt_d.st = PS_CODE;
            end
            PS_CODE: begin
                if (fire) begin
                    nxt_d.code = in_data;
                    nxt_d.cnt  = '0;
                    if ((in_data == OP_RD) || (in_data == OP_WR)) begin
                        nxt_d.st = PS_ADDR;
                    end else if (in_data == OP_RST) begin
                        nxt_d.st = PS_END;
                    end else begin
                        nxt_d.rk = RK_UNK;
                        nxt_d.st = PS_SEND;
                    end
                end
            end
            PS_ADDR: begin
                if (fire) begin
                    nxt_d.addr = (cur_q.addr << 8) | ADDR_W'(in_data);
                    nxt_d.cnt  = cur_q.cnt + 1'b1;
                    if (cur_q.cnt == CNT_W'(AB - 1)) begin
                        nxt_d.cnt = '0;
                        nxt_d.st  = (cur_q.code == OP_WR) ? PS_DATA : PS_END;
                    end
                end
            end
            PS_DATA: begin
                if (fire) begin
                    nxt_d.wdata = (cur_q.wdata << 8) | DATA_W'(in_data);
                    nxt_d.cnt   = cur_q.cnt + 1'b1;
                    if (cur_q.cnt == CNT_W'(DB - 1)) begin
                        nxt_d.cnt = '0;
                        nxt_d.st  = PS_END;
                    end
                end
            end
            PS_END: begin
                if (fire) begin
                    if (in_data == CMD_EOF) begin
                        nxt_d.st = PS_EXEC;
                    end else begin
                        nxt_d.rk = RK_BAD;
                        nxt_d.st = PS_SEND;
                    end
                end
            end
            PS_EXEC: begin
                if (cur_q.code == OP_RD) begin
                    bus_cs   = 1'b1;
                    nxt_d.st = PS_CAPT;
                end else if (cur_q.code == OP_WR) begin
                    bus_cs   = 1'b1;
                    bus_we   = 1'b1;
                    nxt_d.rk = RK_WRITE;
                    nxt_d.st = PS_SEND;
                end else begin
                    core_rst = 1'b1;
                    nxt_d.rk = RK_RESET;
                    nxt_d.st = PS_SEND;
                end
            end
            PS_CAPT: begin
                nxt_d.rdata = bus_rdata;
                nxt_d.rk    = RK_READ;
                nxt_d.st    = PS_SEND;
            end
            PS_SEND: begin
                rsp_load = 1'b1;
                nxt_d.st = PS_DRAIN;
            end
            PS_DRAIN: begin
                if (!tx_busy) nxt_d.st = PS_IDLE;
            end
            default: nxt_d.st = PS_IDLE;
        endcase
    end

    always_comb begin
        rsp_bytes    = '0;
        rsp_len      = '0;
        rsp_bytes[0] = RSP_SOF;
        case (cur_q.rk)
            RK_READ: begin
                rsp_bytes[1] = ST_RD;
                for (int i = 0; i < AB; i++)
                    rsp_bytes[2+i] = cur_q.addr[ADDR_W-1-8*i -: 8];
                for (int j = 0; j < DB; j++)
                    rsp_bytes[2+AB+j] = cur_q.rdata[DATA_W-1-8*j -: 8];
                rsp_bytes[2+AB+DB] = RSP_EOF;
                rsp_len = LEN_W'(3 + AB + DB);
            end
            RK_WRITE: begin
                rsp_bytes[1] = ST_WR;
                for (int i = 0; i < AB; i++)
                    rsp_bytes[2+i] = cur_q.addr[ADDR_W-1-8*i -: 8];
                rsp_bytes[2+AB] = RSP_EOF;
                rsp_len = LEN_W'(3 + AB);
            end
            RK_RESET: begin
                rsp_bytes[1] = ST_RST;
                rsp_bytes[2] = RSP_EOF;
                rsp_len = LEN_W'(3);
            end
            default: begin
                rsp_bytes[1] = (cur_q.rk == RK_UNK) ? ST_UNK : ST_BAD;
                rsp_bytes[2] = cur_q.code;
                rsp_bytes[3] = RSP_EOF;
                rsp_len = LEN_W'(4);
            end
        endcase
    end

    assign bus_addr  = cur_q.addr;
    assign bus_wdata = cur_q.wdata;

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

endmodule

// File: rtl/fce_resp_tx.sv
module fce_resp_tx #(
    parameter int RSP_MAX = 9,
    parameter int LEN_W   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rsp_load,
    input  logic [RSP_MAX-1:0][7:0] rsp_bytes,
    input  logic [LEN_W-1:0]        rsp_len,
    output logic                    tx_busy,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [7:0]              out_data
);

    typedef struct packed {
        logic                    busy;
        logic [RSP_MAX-1:0][7:0] bytes;
        logic [LEN_W-1:0]        len;
        logic [LEN_W-1:0]        idx;
    } tctx_t;

    tctx_t cur_q, nxt_d;

    always_comb begin
        nxt_d     = cur_q;
        tx_busy   = cur_q.busy;
        out_valid = cur_q.busy;
        out_data  = cur_q.bytes[cur_q.idx];
        if (rsp_load) begin
            nxt_d.busy  = 1'b1;
            nxt_d.bytes = rsp_bytes;
            nxt_d.len   = rsp_len;
            nxt_d.idx   = '0;
        end else if (cur_q.busy && out_ready) begin
            if (cur_q.idx == cur_q.len - 1'b1) nxt_d.busy = 1'b0;
            else                               nxt_d.idx  = cur_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

endmodule

// File: rtl/frame_cmd_engine.sv
module frame_cmd_engine #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic              bus_cs,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              core_rst
);

    localparam int RSP_MAX = 3 + ADDR_W / 8 + DATA_W / 8;
    localparam int LEN_W   = $clog2(RSP_MAX + 1);

    logic                    rsp_load;
    logic [RSP_MAX-1:0][7:0] rsp_bytes;
    logic [LEN_W-1:0]        rsp_len;
    logic                    tx_busy;

    fce_cmd_parser #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .RSP_MAX(RSP_MAX),
        .LEN_W  (LEN_W)
    ) u_parser (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_data  (in_data),
        .bus_cs   (bus_cs),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .core_rst (core_rst),
        .rsp_load (rsp_load),
        .rsp_bytes(rsp_bytes),
        .rsp_len  (rsp_len),
        .tx_busy  (tx_busy)
    );

    fce_resp_tx #(
        .RSP_MAX(RSP_MAX),
        .LEN_W  (LEN_W)
    ) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rsp_load (rsp_load),
        .rsp_bytes(rsp_bytes),
        .rsp_len  (rsp_len),
        .tx_busy  (tx_busy),
        .out_valid(out_valid),
        .out_ready(out_ready),
        .out_data (out_data)
    );

endmodule

// File: rtl/fce_checker.sv
module fce_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       bus_cs,
    input logic       core_rst
);

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R9
    cs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cs |=> !bus_cs);

    // R4
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |=> !core_rst);

    // R7
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R5
    action_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_cs && core_rst));

    // R10
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !bus_cs && !core_rst));

endmodule

bind frame_cmd_engine fce_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .bus_cs   (bus_cs),
    .core_rst (core_rst)
);

// File: tb/tb_frame_cmd_engine.sv
module tb_frame_cmd_engine;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_data;
    logic        bus_cs;
    logic        bus_we;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        core_rst;

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_cmd_engine dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .bus_cs(bus_cs), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_rst(core_rst)
    );

    // register model: read data appears the cycle after the select
    logic [31:0] regs [16];
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 16; k++) regs[k] <= '0;
            bus_rdata <= '0;
        end else if (bus_cs) begin
            if (bus_we) regs[bus_addr[3:0]] <= bus_wdata;
            else        bus_rdata <= regs[bus_addr[3:0]];
        end
    end

    int cs_cnt = 0;
    int rst_cnt = 0;
    int cycles = 0;
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst_n && bus_cs)   cs_cnt  <= cs_cnt + 1;
        if (rst_n && core_rst) rst_cnt <= rst_cnt + 1;
    end

    int errors = 0;
    int checks = 0;

    typedef struct packed {
        logic [0:8][7:0] cmd;
        logic [3:0]      clen;
        logic [0:8][7:0] rsp;
        logic [3:0]      rlen;
        logic [1:0]      ncs;
        logic            nrst;
        logic [3:0]      req;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        // R2 write 0x0003
        '{ {8'h55,8'h11,8'h00,8'h03,8'hDE,8'hAD,8'hBE,8'hEF,8'hAA}, 4'd9,
           {8'hAA,8'h7E,8'h00,8'h03,8'h55,8'h00,8'h00,8'h00,8'h00}, 4'd5, 2'd1, 1'b0, 4'd2 },
        // R3 read 0x0003
        '{ {8'h55,8'h10,8'h00,8'h03,8'hAA,8'h00,8'h00,8'h00,8'h00}, 4'd5,
           {8'hAA,8'h7F,8'h00,8'h03,8'hDE,8'hAD,8'hBE,8'hEF,8'h55}, 4'd9, 2'd1, 1'b0, 4'd3 },
        // R4 reset
        '{ {8'h55,8'h01,8'hAA,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00}, 4'd3,
           {8'hAA,8'h7D,8'h55,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00}, 4'd3, 2'd0, 1'b1, 4'd4 },
        // R5 unknown code
        '{ {8'h55,8'h22,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00}, 4'd2,
           {8'hAA,8'hFE,8'h22,8'h55,8'h00,8'h00,8'h00,8'h00,8'h00}, 4'd4, 2'd0, 1'b0, 4'd5 },
        // R6 write with bad end marker
        '{ {8'h55,8'h11,8'h00,8'h05,8'h11,8'h22,8'h33,8'h44,8'h00}, 4'd9,
           {8'hAA,8'hFD,8'h11,8'h55,8'h00,8'h00,8'h00,8'h00,8'h00}, 4'd4, 2'd0, 1'b0, 4'd6 },
        // R6 register 5 still holds zero
        '{ {8'h55,8'h10,8'h00,8'h05,8'hAA,8'h00,8'h00,8'h00,8'h00}, 4'd5,
           {8'hAA,8'h7F,8'h00,8'h05,8'h00,8'h00,8'h00,8'h00,8'h55}, 4'd9, 2'd1, 1'b0, 4'd6 },
        // R1 idle noise before a read
        '{ {8'h12,8'h34,8'h55,8'h10,8'h00,8'h03,8'hAA,8'h00,8'h00}, 4'd7,
           {8'hAA,8'h7F,8'h00,8'h03,8'hDE,8'hAD,8'hBE,8'hEF,8'h55}, 4'd9, 2'd1, 1'b0, 4'd1 },
        // R6 read with bad end marker
        '{ {8'h55,8'h10,8'h00,8'h03,8'hAB,8'h00,8'h00,8'h00,8'h00}, 4'd5,
           {8'hAA,8'hFD,8'h10,8'h55,8'h00,8'h00,8'h00,8'h00,8'h00}, 4'd4, 2'd0, 1'b0, 4'd6 },
        // R2 write with nonzero high address byte
        '{ {8'h55,8'h11,8'h12,8'h07,8'h01,8'h02,8'h03,8'h04,8'hAA}, 4'd9,
           {8'hAA,8'h7E,8'h12,8'h07,8'h55,8'h00,8'h00,8'h00,8'h00}, 4'd5, 2'd1, 1'b0, 4'd2 },
        // R3 read back, byte order
        '{ {8'h55,8'h10,8'h12,8'h07,8'hAA,8'h00,8'h00,8'h00,8'h00}, 4'd5,
           {8'hAA,8'h7F,8'h12,8'h07,8'h01,8'h02,8'h03,8'h04,8'h55}, 4'd9, 2'd1, 1'b0, 4'd3 }
    };

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic put_byte(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    // collects up to n bytes; returns them and the number of R7 violations
    task automatic get_bytes(input int n, input bit stall,
                             output logic [0:8][7:0] got, output int cnt,
                             output int overlap);
        int waitc = 0;
        int phase = 0;
        got = '0;
        cnt = 0;
        overlap = 0;
        while (cnt < n && waitc < 400) begin
            @(negedge clk);
            waitc++;
            phase++;
            out_ready = stall ? phase[0] : 1'b1;
            if (out_valid && in_ready) overlap++;
            if (out_valid && out_ready) begin
                got[cnt] = out_data;
                cnt++;
            end
        end
        @(negedge clk);
        out_ready = 1'b1;
        for (int k = 0; k < 4; k++) begin
            if (out_valid) cnt++;
            @(negedge clk);
        end
    endtask

    task automatic run_vec(input vec_t v, input bit stall, input string tag);
        logic [0:8][7:0] got;
        int cnt, ov, cs0, rs0;
        cs0 = cs_cnt;
        rs0 = rst_cnt;
        for (int i = 0; i < int'(v.clen); i++) put_byte(v.cmd[i]);
        get_bytes(int'(v.rlen), stall, got, cnt, ov);
        check(cnt == int'(v.rlen), tag, "response length", cnt, v.rlen);
        check(got == v.rsp, tag, "response bytes", got, v.rsp);
        check(cs_cnt - cs0 == int'(v.ncs), tag, "bus select cycles (R9)", cs_cnt - cs0, v.ncs);
        check(rst_cnt - rs0 == int'(v.nrst), tag, "reset pulses", rst_cnt - rs0, v.nrst);
        check(ov == 0, "R7", "input taken while responding", ov, 0);
    endtask

    initial begin
        int quiet;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        check(!out_valid && !bus_cs && !core_rst && in_ready, "R10", "reset state",
              {out_valid, bus_cs, core_rst, in_ready}, 4'b0001);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready && !out_valid, "R10", "ready after reset",
              {in_ready, out_valid}, 2'b10);

        for (int v = 0; v < NVEC; v++)
            run_vec(VECS[v], 1'b0, $sformatf("R%0d", VECS[v].req));

        // R1: noise alone draws no response
        begin
            int cs0, rs0;
            cs0 = cs_cnt;
            rs0 = rst_cnt;
            put_byte(8'hAA);
            put_byte(8'h00);
            put_byte(8'h11);
            quiet = 0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (out_valid) quiet++;
            end
            check(quiet == 0, "R1", "response to noise", quiet, 0);
            check(cs_cnt == cs0 && rst_cnt == rs0, "R1", "action on noise",
                  (cs_cnt - cs0) + (rst_cnt - rs0), 0);
        end

        // R8: read under receiver backpressure
        run_vec(VECS[9], 1'b1, "R8");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait (cycles >= WDOG_LIMIT);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d cycles expected=done", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule